// File: doc/BRIEF.md
# Byte-Lane Packing FIFO with Fill Threshold

This block is the per-stream staging buffer of a transfer engine. It holds sixteen bytes, arranged as byte lanes in a ring, between a source side and a destination side. Each side states its own item size on every access: byte, half-word or word. Narrow items pushed in are therefore packed into wider items on the way out, and wide items are split into narrow ones. Byte order is little-endian throughout: the byte pushed first always lands in the least significant lane of the item that pops out.

The destination side is treated as the memory side. A programmed fill threshold (a quarter, half, three quarters or all of the storage) raises a memory request. The request stays up until the threshold's worth of bytes has been popped. A combinational legality check compares the memory burst length, times the destination item size, against the threshold. Any pairing that cannot be served by a whole number of bursts is flagged, and that flag keeps the request down. With the buffer disabled the block acts as a one-item pass-through. A flush input drains whatever remains, including a trailing partial item.

A small state machine sequences the block. FILL is the reset state: it accumulates data and goes to BURST once the threshold is met on a legal setting, to FLUSH when flush is seen, and to DIRECT when the buffer is disabled and empty. BURST holds the request and returns to FILL once the threshold amount has been popped or the setting turns illegal, or goes to FLUSH on flush. FLUSH drains and returns to FILL when empty and flush is low. DIRECT is pass-through and returns to FILL when the buffer is enabled and empty.

Top module: `lane_pack_fifo`

## Requirements
- R1: After reset, level is 0, empty is 1, full is 0, mem_req is 0, cfg_err reflects only the configuration, and push_ready is 1 for any item size.
- R2: Size codes are 0 = byte, 1 = half-word, 2 = word. Narrow items pushed in sequence pop out as a wider item, with the first-pushed item in bits [7:0] (little-endian). Push data bytes above the source item size are ignored.
- R3: A wide pushed item pops out as narrow items, least significant bytes first.
- R4: push_ready is 1 in FILL or BURST exactly when the free byte count is at least the source item size. full is 1 at 16 bytes. A push while push_ready is 0 changes nothing.
- R5: Outside FLUSH and DIRECT, pop_valid is 1 exactly when level is at least the destination item size.
- R6: Threshold codes 0..3 select 4, 8, 12 or 16 bytes. mem_req rises one cycle after level reaches the threshold on a legal setting. It stays high until that many bytes have been popped, and falls in the cycle after the last of them.
- R7: Burst codes 0, 1 and 2 mean 4, 8 and 16 beats; code 3 is reserved. cfg_err is 1 when the code is reserved, or when beats times the destination item size exceeds the threshold bytes or does not divide them evenly. While cfg_err is 1, mem_req does not rise.
- R8: With cfg_fifo_en at 0 and the buffer empty, the block enters DIRECT in the next cycle. There it holds at most one item, push_ready is 1 only when empty, and the item pops out in its own source size with upper bytes zero, whatever pop_width says.
- R9: A cycle with flush at 1 enters FLUSH. There push_ready is 0, pop_valid is 1 while any byte remains, and each pop removes the smaller of level and the destination size, with missing upper bytes read as zero. FILL follows once level is 0 and flush is 0.
- R10: level always equals the bytes pushed minus the bytes popped, and never exceeds 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_fifo_en | input | 1 | 1 = packing buffer, 0 = single-item pass-through |
| cfg_thresh | input | 2 | Fill threshold code (4/8/12/16 bytes) |
| cfg_burst | input | 2 | Memory burst length code (4/8/16 beats, 3 reserved) |
| flush | input | 1 | Start draining remaining data |
| push_valid | input | 1 | Source item offered |
| push_width | input | 2 | Source item size code |
| push_data | input | 32 | Source item, least significant bytes used |
| push_ready | output | 1 | Source item can be accepted |
| pop_en | input | 1 | Destination takes an item |
| pop_width | input | 2 | Destination item size code |
| pop_valid | output | 1 | An item is available |
| pop_data | output | 32 | Destination item, unused upper bytes zero |
| level | output | 5 | Bytes held |
| full | output | 1 | All 16 bytes occupied |
| empty | output | 1 | No byte held |
| mem_req | output | 1 | Memory-side request |
| cfg_err | output | 1 | Burst length cannot be met from the threshold |

## Verification
The bench builds the block with its default depth of sixteen byte lanes and a 32-bit item port. At that depth every threshold code, and every row of the burst legality rule, can be reached with real data. The table of size pairs fills the ring completely, so pointer wrap-around and the full flag come up in every pass. The directed part reaches the near-full boundary, where a half-word is refused but a byte still fits. It also covers a two-step flush that ends in a one-byte partial item, and a pass-through item whose pop_width disagrees with its own size.

// File: rtl/lpf_pkg.sv
package lpf_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } item_sz_e;

    typedef enum logic [1:0] {
        ST_FILL   = 2'd0,
        ST_BURST  = 2'd1,
        ST_FLUSH  = 2'd2,
        ST_DIRECT = 2'd3
    } lpf_state_e;

    // bytes carried by one item of the given size code (reserved treated as word)
    function automatic logic [2:0] sz_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // beats per memory burst; zero marks the reserved code
    function automatic int burst_beats(input logic [1:0] code);
        case (code)
            2'd0:    return 4;
            2'd1:    return 8;
            2'd2:    return 16;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/lpf_store.sv
module lpf_store #(
    parameter int NB = 16,
    parameter int IW = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(IW/8+1)-1:0] wr_cnt,
    input  logic [IW-1:0]            wr_data,
    input  logic                     rd_en,
    input  logic [$clog2(IW/8+1)-1:0] rd_cnt,
    output logic [IW-1:0]            peek,
    output logic [$clog2(NB+1)-1:0]  level
);
    localparam int PW = $clog2(NB);
    localparam int LW = $clog2(NB + 1);
    localparam int IB = IW / 8;
    localparam int SW = (IB > 1) ? $clog2(IB) : 1;

    logic [7:0]    lanes   [NB];
    logic [7:0]    wr_b    [IB];
    logic [7:0]    lane_wd [NB];
    logic [NB-1:0] lane_we;
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] cnt;

    // split the incoming item into bytes
    for (genvar b = 0; b < IB; b++) begin : g_split
        assign wr_b[b] = wr_data[8*b +: 8];
    end

    // each lane decides whether it receives a byte and which one
    for (genvar i = 0; i < NB; i++) begin : g_lane
        logic [PW-1:0] off;
        assign off        = PW'(i) - wr_ptr;
        assign lane_we[i] = wr_en && (int'(off) < int'(wr_cnt));
        assign lane_wd[i] = wr_b[off[SW-1:0]];
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NB; i++) begin
            if (lane_we[i]) lanes[i] <= lane_wd[i];
        end
    end

    // read window: IB consecutive lanes starting at the read pointer
    for (genvar k = 0; k < IB; k++) begin : g_peek
        assign peek[8*k +: 8] = lanes[rd_ptr + PW'(k)];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + PW'(wr_cnt);
            if (rd_en) rd_ptr <= rd_ptr + PW'(rd_cnt);
            cnt <= cnt + (wr_en ? LW'(wr_cnt) : LW'(0)) - (rd_en ? LW'(rd_cnt) : LW'(0));
        end
    end

    assign level = cnt;

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(cnt) + int'(wr_cnt)) <= NB);

    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> int'(rd_cnt) <= int'(cnt));

    p_level_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) <= NB);

endmodule

// File: rtl/lpf_legal.sv
module lpf_legal #(
    parameter int NB = 16
) (
    input  logic [1:0]              thr_code,
    input  logic [1:0]              burst_code,
    input  logic [1:0]              dst_code,
    output logic [$clog2(NB+1)-1:0] thr_bytes,
    output logic                    err
);
    import lpf_pkg::*;
    localparam int LW = $clog2(NB + 1);
    localparam int QB = NB / 4;

    int thr_b, beats, bb;

    always_comb begin
        thr_b = (int'(thr_code) + 1) * QB;
        beats = burst_beats(burst_code);
        bb    = beats * int'(sz_bytes(dst_code));
        if (beats == 0)          err = 1'b1;
        else if (bb > thr_b)     err = 1'b1;
        else if ((thr_b % bb) != 0) err = 1'b1;
        else                     err = 1'b0;
        thr_bytes = LW'(thr_b);
    end

endmodule

// File: rtl/lpf_ctrl.sv
module lpf_ctrl #(
    parameter int NB = 16,
    parameter int BW = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fifo_en,
    input  logic                    flush,
    input  logic                    cfg_err,
    input  logic [$clog2(NB+1)-1:0] level,
    input  logic [$clog2(NB+1)-1:0] thr_bytes,
    input  logic                    pop_fire,
    input  logic [BW-1:0]           pop_take,
    output logic                    mem_req,
    output logic                    flushing,
    output logic                    direct_mode
);
    import lpf_pkg::*;
    localparam int LW = $clog2(NB + 1);

    lpf_state_e    state, state_nxt;
    logic [LW:0]   moved, moved_nxt;

    assign moved_nxt = moved + (pop_fire ? (LW+1)'(pop_take) : (LW+1)'(0));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FILL;
            moved <= '0;
        end else begin
            state <= state_nxt;
            moved <= (state == ST_BURST && state_nxt == ST_BURST) ? moved_nxt : '0;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_FILL: begin
                if (flush)                                   state_nxt = ST_FLUSH;
                else if (!fifo_en && level == '0)            state_nxt = ST_DIRECT;
                else if (fifo_en && !cfg_err && level >= thr_bytes) state_nxt = ST_BURST;
            end
            ST_BURST: begin
                if (flush)                                   state_nxt = ST_FLUSH;
                else if (cfg_err)                            state_nxt = ST_FILL;
                else if (moved_nxt >= {1'b0, thr_bytes})     state_nxt = ST_FILL;
            end
            ST_FLUSH: begin
                if (level == '0 && !flush)                   state_nxt = ST_FILL;
            end
            ST_DIRECT: begin
                if (fifo_en && level == '0)                  state_nxt = ST_FILL;
            end
        endcase
    end

    always_comb begin
        mem_req     = 1'b0;
        flushing    = 1'b0;
        direct_mode = 1'b0;
        unique case (state)
            ST_FILL:   ;
            ST_BURST:  mem_req     = 1'b1;
            ST_FLUSH:  flushing    = 1'b1;
            ST_DIRECT: direct_mode = 1'b1;
        endcase
    end

    p_req_after_threshold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(level) >= $past(thr_bytes));

    p_err_blocks_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> !mem_req);

endmodule

// File: rtl/lane_pack_fifo.sv
module lane_pack_fifo #(
    parameter int DEPTH_BYTES = 16,
    parameter int ITEM_W      = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_fifo_en,
    input  logic [1:0]                       cfg_thresh,
    input  logic [1:0]                       cfg_burst,
    input  logic                             flush,
    input  logic                             push_valid,
    input  logic [1:0]                       push_width,
    input  logic [ITEM_W-1:0]                push_data,
    output logic                             push_ready,
    input  logic                             pop_en,
    input  logic [1:0]                       pop_width,
    output logic                             pop_valid,
    output logic [ITEM_W-1:0]                pop_data,
    output logic [$clog2(DEPTH_BYTES+1)-1:0] level,
    output logic                             full,
    output logic                             empty,
    output logic                             mem_req,
    output logic                             cfg_err
);
    import lpf_pkg::*;
    localparam int NB = DEPTH_BYTES;
    localparam int LW = $clog2(NB + 1);
    localparam int IB = ITEM_W / 8;
    localparam int BW = $clog2(IB + 1);

    logic [BW-1:0]     src_b, dst_b, take, held_b;
    logic [ITEM_W-1:0] peek;
    logic [LW-1:0]     thr_bytes, free_b;
    logic              flushing, direct_mode, push_fire, pop_fire;

    assign src_b  = BW'(sz_bytes(push_width));
    assign dst_b  = BW'(sz_bytes(pop_width));
    assign free_b = LW'(NB) - level;

    // size of the item currently held in pass-through mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         held_b <= '0;
        else if (push_fire) held_b <= src_b;
    end

    always_comb begin
        if (direct_mode) begin
            push_ready = (level == '0);
            pop_valid  = (level != '0);
            take       = held_b;
        end else if (flushing) begin
            push_ready = 1'b0;
            pop_valid  = (level != '0);
            take       = (level < LW'(dst_b)) ? level[BW-1:0] : dst_b;
        end else begin
            push_ready = (free_b >= LW'(src_b));
            pop_valid  = (level >= LW'(dst_b));
            take       = dst_b;
        end
    end

    assign push_fire = push_valid && push_ready;
    assign pop_fire  = pop_en && pop_valid;

    for (genvar k = 0; k < IB; k++) begin : g_mask
        assign pop_data[8*k +: 8] = (BW'(k) < take) ? peek[8*k +: 8] : 8'h00;
    end

    assign full  = (level == LW'(NB));
    assign empty = (level == '0);

    lpf_store #(.NB(NB), .IW(ITEM_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push_fire),
        .wr_cnt  (src_b),
        .wr_data (push_data),
        .rd_en   (pop_fire),
        .rd_cnt  (take),
        .peek    (peek),
        .level   (level)
    );

    lpf_legal #(.NB(NB)) u_legal (
        .thr_code   (cfg_thresh),
        .burst_code (cfg_burst),
        .dst_code   (pop_width),
        .thr_bytes  (thr_bytes),
        .err        (cfg_err)
    );

    lpf_ctrl #(.NB(NB), .BW(BW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_en     (cfg_fifo_en),
        .flush       (flush),
        .cfg_err     (cfg_err),
        .level       (level),
        .thr_bytes   (thr_bytes),
        .pop_fire    (pop_fire),
        .pop_take    (take),
        .mem_req     (mem_req),
        .flushing    (flushing),
        .direct_mode (direct_mode)
    );

    p_direct_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        direct_mode |-> int'(level) <= IB);

    p_flush_blocks_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flushing && push_valid) |=> (level <= $past(level)));

endmodule

// File: tb/lane_pack_fifo_test.sv
`timescale 1ns/1ps
module lane_pack_fifo_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_fifo_en = 1'b1;
    logic [1:0]  cfg_thresh = 2'd3;
    logic [1:0]  cfg_burst = 2'd0;
    logic        flush = 1'b0;
    logic        push_valid = 1'b0;
    logic [1:0]  push_width = 2'd2;
    logic [31:0] push_data = '0;
    logic        push_ready;
    logic        pop_en = 1'b0;
    logic [1:0]  pop_width = 2'd2;
    logic        pop_valid;
    logic [31:0] pop_data;
    logic [4:0]  level;
    logic        full, empty, mem_req, cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    lane_pack_fifo uut (
        .clk(clk), .rst_n(rst_n), .cfg_fifo_en(cfg_fifo_en), .cfg_thresh(cfg_thresh),
        .cfg_burst(cfg_burst), .flush(flush), .push_valid(push_valid),
        .push_width(push_width), .push_data(push_data), .push_ready(push_ready),
        .pop_en(pop_en), .pop_width(pop_width), .pop_valid(pop_valid),
        .pop_data(pop_data), .level(level), .full(full), .empty(empty),
        .mem_req(mem_req), .cfg_err(cfg_err)
    );

    // size-pair table: source size, destination size, 16-byte stream
    localparam logic [1:0] VS [7] = '{2'd0, 2'd1, 2'd2, 2'd2, 2'd0, 2'd1, 2'd2};
    localparam logic [1:0] VD [7] = '{2'd2, 2'd2, 2'd0, 2'd1, 2'd1, 2'd0, 2'd2};
    localparam logic [127:0] VSTREAM [7] = '{
        128'h0f0e0d0c_0b0a0908_07060504_03020100,
        128'h1f1e1d1c_1b1a1918_17161514_13121110,
        128'hfedcba98_76543210_89abcdef_01234567,
        128'h55aa33cc_0ff0a5a5_c3c3e1e1_12345678,
        128'h8877_6655_4433_2211_00ff_eedd_ccbb_aa99,
        128'hdeadbeef_cafef00d_01020304_a0b0c0d0,
        128'h11111111_22222222_33333333_44444444
    };

    function automatic int nbytes(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] slice(input logic [127:0] s, input int off, input int n);
        logic [127:0] t;
        logic [31:0]  v;
        t = s >> (8 * off);
        v = t[31:0];
        for (int b = n; b < 4; b++) v[8*b +: 8] = 8'h00;
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push_item(input logic [1:0] w, input logic [31:0] d);
        push_width = w;
        push_data  = d;
        push_valid = 1'b1;
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic pop_chk(input string req, input logic [1:0] w, input logic [31:0] exp);
        pop_width = w;
        #1;
        chk({req, " pop_valid"}, 32'(pop_valid), 32'd1);
        chk({req, " pop_data"}, pop_data, exp);
        pop_en = 1'b1;
        @(negedge clk);
        pop_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        #1;
        // R1 reset state
        chk("R1 level", 32'(level), 32'd0);
        chk("R1 empty", 32'(empty), 32'd1);
        chk("R1 full", 32'(full), 32'd0);
        chk("R1 mem_req", 32'(mem_req), 32'd0);
        chk("R1 push_ready", 32'(push_ready), 32'd1);
        chk("R1 cfg_err", 32'(cfg_err), 32'd0);
        @(negedge clk);

        // R2/R3 size-pair table
        for (int v = 0; v < 7; v++) begin
            int sb, db;
            sb = nbytes(VS[v]);
            db = nbytes(VD[v]);
            cfg_thresh = 2'd3;
            cfg_burst  = 2'd0;
            for (int i = 0; i < 16 / sb; i++) begin
                logic [31:0] d;
                d = slice(VSTREAM[v], i * sb, sb);
                for (int b = sb; b < 4; b++) d[8*b +: 8] = 8'hEE;
                push_item(VS[v], d);
            end
            #1;
            chk("R10 level after fill", 32'(level), 32'd16);
            chk("R4 full after fill", 32'(full), 32'd1);
            for (int j = 0; j < 16 / db; j++)
                pop_chk((sb < db) ? "R2 pack" : "R3 unpack", VD[v], slice(VSTREAM[v], j * db, db));
            #1;
            chk("R10 empty after drain", 32'(empty), 32'd1);
            @(negedge clk);
        end

        // R7 legality rule
        cfg_thresh = 2'd0; cfg_burst = 2'd0; pop_width = 2'd0; #1;
        chk("R7 byte q1 b4", 32'(cfg_err), 32'd0);
        cfg_burst = 2'd1; #1;
        chk("R7 byte q1 b8", 32'(cfg_err), 32'd1);
        cfg_thresh = 2'd2; cfg_burst = 2'd1; #1;
        chk("R7 byte q3 b8", 32'(cfg_err), 32'd1);
        cfg_thresh = 2'd3; cfg_burst = 2'd2; #1;
        chk("R7 byte full b16", 32'(cfg_err), 32'd0);
        pop_width = 2'd1; cfg_thresh = 2'd0; cfg_burst = 2'd0; #1;
        chk("R7 half q1 b4", 32'(cfg_err), 32'd1);
        cfg_thresh = 2'd3; cfg_burst = 2'd1; #1;
        chk("R7 half full b8", 32'(cfg_err), 32'd0);
        pop_width = 2'd2; cfg_thresh = 2'd3; cfg_burst = 2'd0; #1;
        chk("R7 word full b4", 32'(cfg_err), 32'd0);
        cfg_thresh = 2'd1; #1;
        chk("R7 word half b4", 32'(cfg_err), 32'd1);
        cfg_thresh = 2'd3; cfg_burst = 2'd3; #1;
        chk("R7 reserved burst", 32'(cfg_err), 32'd1);
        @(negedge clk);

        // R7 illegal setting never raises the request
        pop_width = 2'd2; cfg_thresh = 2'd2; cfg_burst = 2'd0;
        for (int i = 0; i < 3; i++) push_item(2'd2, 32'h1000_0000 + i);
        idle(2);
        #1;
        chk("R7 no req when illegal", 32'(mem_req), 32'd0);
        for (int i = 0; i < 3; i++) pop_chk("R7 drain", 2'd2, 32'h1000_0000 + i);

        // R6 threshold request timing: 8 bytes, byte destination, 4-beat bursts
        cfg_thresh = 2'd1; cfg_burst = 2'd0; pop_width = 2'd0;
        push_item(2'd2, 32'h44332211);
        push_item(2'd2, 32'h88776655);
        #1;
        chk("R6 req not yet", 32'(mem_req), 32'd0);
        @(negedge clk); #1;
        chk("R6 req raised", 32'(mem_req), 32'd1);
        for (int j = 0; j < 4; j++) pop_chk("R6 bytes", 2'd0, 32'h11 * (j + 1));
        #1;
        chk("R6 req held mid", 32'(mem_req), 32'd1);
        for (int j = 4; j < 8; j++) pop_chk("R6 bytes", 2'd0, 32'h11 * (j + 1));
        #1;
        chk("R6 req dropped", 32'(mem_req), 32'd0);
        @(negedge clk);

        // R4 near-full boundary
        cfg_thresh = 2'd3; cfg_burst = 2'd0; pop_width = 2'd2;
        for (int i = 0; i < 3; i++) push_item(2'd2, 32'hA0A0A0A0 + i);
        push_item(2'd0, 32'h01); push_item(2'd0, 32'h02); push_item(2'd0, 32'h03);
        push_width = 2'd1; #1;
        chk("R4 half refused at 15", 32'(push_ready), 32'd0);
        push_width = 2'd0; #1;
        chk("R4 byte fits at 15", 32'(push_ready), 32'd1);
        @(negedge clk);
        push_item(2'd0, 32'h04);
        #1;
        chk("R4 full", 32'(full), 32'd1);
        push_item(2'd0, 32'hFF);
        #1;
        chk("R4 push ignored when full", 32'(level), 32'd16);
        for (int i = 0; i < 3; i++) pop_chk("R4 drain", 2'd2, 32'hA0A0A0A0 + i);
        pop_chk("R4 last word", 2'd2, 32'h04030201);

        // R5 / R9 flush with half-word destination
        idle(1);
        cfg_thresh = 2'd3; pop_width = 2'd2;
        push_item(2'd0, 32'hAA); push_item(2'd0, 32'hBB); push_item(2'd0, 32'hCC);
        #1;
        chk("R5 no pop below size", 32'(pop_valid), 32'd0);
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        #1;
        chk("R9 push blocked", 32'(push_ready), 32'd0);
        pop_chk("R9 flush full item", 2'd1, 32'h0000BBAA);
        pop_chk("R9 flush partial", 2'd1, 32'h000000CC);
        #1;
        chk("R9 still flushing", 32'(push_ready), 32'd0);
        @(negedge clk); #1;
        chk("R9 back to fill", 32'(push_ready), 32'd1);
        @(negedge clk);

        // R8 pass-through
        cfg_fifo_en = 1'b0;
        idle(1);
        push_item(2'd1, 32'hDEADBEEF);
        #1;
        chk("R8 one item held", 32'(push_ready), 32'd0);
        chk("R8 level", 32'(level), 32'd2);
        @(negedge clk);
        push_item(2'd2, 32'h12345678);
        pop_chk("R8 item in own size", 2'd2, 32'h0000BEEF);
        #1;
        chk("R8 empty after pop", 32'(empty), 32'd1);
        chk("R8 ready again", 32'(push_ready), 32'd1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule